// File: doc/BRIEF.md
# Linear CCD Line Pixel Classifier with Black-Level Correction

This block sits behind the converter of one colour channel of a linear CCD sensor. It receives one digitised sample per pixel, together with a start-of-line flag on the first sample of each line. It counts pixel positions within the line and labels every sample as a dummy, optical-black or effective pixel. A black level is formed as the rounded mean of the optical-black pixels at the head of the line, and that same line's effective pixels leave the block with the black level subtracted. Results below zero are clamped to zero.

In measurement mode the block also partitions the effective pixels into runs of fixed length. For each run it reports the largest sample, the smallest sample and the rounded mean, which is the raw material for a response-uniformity check. The last run of a line may be shorter than the others, and its mean is taken over the pixels it actually holds. A start-of-line flag that arrives before the line is complete discards the unfinished line, flags an error and starts the new line. Every division uses a constant reciprocal multiply, so the block contains no iterative divider.

Top module: `ccd_line_classifier`

The control is a four-state machine over the line: S_IDLE (waiting for a line start), S_LEAD (leading dummy and optical-black section), S_EFF (effective pixels) and S_TRAIL (trailing dummies). Its transitions are START (S_IDLE to S_LEAD on a start flag), TO_EFF (S_LEAD to S_EFF when the first effective position is taken), TO_TRAIL (S_EFF to S_TRAIL after the last effective position), DONE (S_EFF or S_TRAIL to S_IDLE when the final position of the line is taken) and ABORT (any busy state to S_LEAD on an early start flag).

## Requirements
- R1: A sample taken with `in_sol` high is position 1, and each further taken sample is the next position. Exactly one cycle after a sample is taken, `out_valid` is high and `out_tag` carries its class: 1 for positions OB_FIRST..OB_LAST, 2 for positions LEAD+1..LEAD+EFF, and 0 for every other position. For tag 2, `out_idx` equals position minus LEAD, which runs from 1 to EFF.
- R2: While the block is idle (before the first line start, or after position LEAD+EFF+TRAIL has been taken), a sample with `in_sol` low is ignored, and `out_valid` stays low in the following cycle.
- R3: One cycle after position OB_LAST is taken, `black_level` equals floor((S + floor(N/2)) / N). Here S is the sum of that line's optical-black samples and N = OB_LAST-OB_FIRST+1. At the same time `black_valid` goes high. `black_valid` is low in the cycle that follows a line start.
- R4: For an effective pixel, `out_pix` equals the sample minus the current line's `black_level`, or 0 when the sample is smaller than `black_level`.
- R5: For dummy and optical-black pixels, `out_pix` equals the raw sample.
- R6: In measurement mode the effective pixels of a line are grouped into consecutive blocks of BLK pixels, with blocks numbered from 0. The output cycle of each block's last pixel carries `blk_valid` high, `blk_idx` set to the block number, `blk_max` and `blk_min` set to the block's extreme samples, and `blk_mean` set to floor((sum + floor(n/2)) / n), where n is the number of pixels in the block.
- R7: When EFF is not a multiple of BLK, the final block closes on effective pixel EFF with n = EFF mod BLK, and its mean uses that count.
- R8: `meas_mode` is sampled only with a line-start sample. Changing it later in the line has no effect. In a line started with `meas_mode` low, `blk_valid` stays low.
- R9: A line start taken while a line is in progress abandons that line. In the cycle that outputs the new position 1, `line_err` is high for one cycle. The new line is then processed exactly like a line started from idle. `line_err` is low at every other time.
- R10: After reset, `out_valid`, `line_err`, `black_valid` and `blk_valid` are low and `black_level` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_sol | input | 1 | Sample is the first pixel of a line |
| in_sample | input | DW | Digitised pixel value |
| meas_mode | input | 1 | Block measurement enable, sampled with the line start |
| out_valid | output | 1 | Output sample present |
| out_tag | output | 2 | Pixel class: 0 dummy, 1 optical black, 2 effective |
| out_pix | output | DW | Corrected value for effective pixels, raw value for the others |
| out_idx | output | $clog2(EFF+1) | Effective pixel number, 0 for other classes |
| line_err | output | 1 | Pulse when a line was cut short by a new start |
| black_level | output | DW | Black level of the current line |
| black_valid | output | 1 | Black level for the current line is ready |
| blk_valid | output | 1 | Block statistics present |
| blk_idx | output | $clog2(ceil(EFF/BLK)+1) | Block number within the line |
| blk_max | output | DW | Largest sample in the block |
| blk_min | output | DW | Smallest sample in the block |
| blk_mean | output | DW | Rounded mean of the block |

## Verification
The bench builds the block with 8-bit samples, 10 leading positions, 5 optical-black pixels at positions 3 to 7, 23 effective pixels, 2 trailing dummies and blocks of 5. A whole line is therefore 35 samples, and every region boundary, the odd optical-black count (which rules out a shift in place of the divide), four full blocks and a short final block of 3 all fall within a few dozen cycles. With these values several complete lines can run, along with a line that is cut short in the middle of a block, so the abort path and block restart are exercised next to ordinary lines with many clamped pixels.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    typedef enum logic [1:0] {
        TAG_DUMMY = 2'd0,
        TAG_OB    = 2'd1,
        TAG_EFF   = 2'd2
    } pix_tag_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_EFF,
        S_TRAIL
    } line_state_t;

endpackage

// File: rtl/recip_mean.sv
// Rounded mean by a constant divisor: floor((num + DIV/2) / DIV),
// computed as a multiply by a ceiling reciprocal and a right shift.
module recip_mean #(
    parameter int NUMW = 16,
    parameter int DIV  = 50,
    parameter int OUTW = 12
) (
    input  logic [NUMW-1:0] num,
    output logic [OUTW-1:0] mean
);
    localparam int DB  = $clog2(DIV + 1);
    localparam int SH  = NUMW + DB + 1;
    localparam int RW  = SH + 1;
    localparam int PRW = NUMW + 1 + RW;
    localparam longint unsigned RECIP =
        ((64'd1 << SH) + 64'(DIV) - 64'd1) / 64'(DIV);

    logic [NUMW:0]  biased;
    logic [PRW-1:0] prod;
    logic [PRW-1:0] shifted;

    always_comb begin
        biased  = {1'b0, num} + (NUMW+1)'(DIV / 2);
        prod    = PRW'(biased) * PRW'(RECIP);
        shifted = prod >> SH;
        mean    = shifted[OUTW-1:0];
    end

endmodule

// File: rtl/blk_stats.sv
// Per-block max/min/mean over consecutive effective pixels.
module blk_stats #(
    parameter int DW  = 12,
    parameter int BLK = 100,
    parameter int EFF = 10680
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en,
    input  logic                                first,
    input  logic                                last,
    input  logic [DW-1:0]                       sample,
    output logic                                blk_valid,
    output logic [$clog2((EFF+BLK-1)/BLK+1)-1:0] blk_idx,
    output logic [DW-1:0]                       blk_max,
    output logic [DW-1:0]                       blk_min,
    output logic [DW-1:0]                       blk_mean
);
    localparam int CW  = $clog2(BLK + 1);
    localparam int SW  = DW + $clog2(BLK + 1);
    localparam int NB  = (EFF + BLK - 1) / BLK;
    localparam int BW  = $clog2(NB + 1);
    localparam int REM = EFF % BLK;

    logic [CW-1:0] cnt_q, cur_cnt;
    logic [DW-1:0] max_q, min_q, cur_max, cur_min;
    logic [SW-1:0] sum_q, cur_sum;
    logic [BW-1:0] no_q, cur_no;
    logic          start, close;
    logic [DW-1:0] mean_full, mean_last;

    always_comb begin
        start   = first || (cnt_q == '0);
        cur_cnt = start ? CW'(1) : cnt_q + 1'b1;
        cur_max = (start || sample > max_q) ? sample : max_q;
        cur_min = (start || sample < min_q) ? sample : min_q;
        cur_sum = start ? SW'(sample) : sum_q + SW'(sample);
        cur_no  = first ? '0 : no_q;
        close   = (cur_cnt == CW'(BLK)) || last;
    end

    recip_mean #(.NUMW(SW), .DIV(BLK), .OUTW(DW)) u_mean_full (
        .num  (cur_sum),
        .mean (mean_full)
    );

    generate
        if (REM != 0) begin : g_short_tail
            logic [DW-1:0] mean_rem;
            recip_mean #(.NUMW(SW), .DIV(REM), .OUTW(DW)) u_mean_rem (
                .num  (cur_sum),
                .mean (mean_rem)
            );
            assign mean_last = last ? mean_rem : mean_full;
        end else begin : g_even_tail
            assign mean_last = mean_full;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            max_q     <= '0;
            min_q     <= '0;
            sum_q     <= '0;
            no_q      <= '0;
            blk_valid <= 1'b0;
            blk_idx   <= '0;
            blk_max   <= '0;
            blk_min   <= '0;
            blk_mean  <= '0;
        end else begin
            blk_valid <= 1'b0;
            if (en) begin
                if (close) begin
                    cnt_q     <= '0;
                    no_q      <= cur_no + 1'b1;
                    blk_valid <= 1'b1;
                    blk_idx   <= cur_no;
                    blk_max   <= cur_max;
                    blk_min   <= cur_min;
                    blk_mean  <= mean_last;
                end else begin
                    cnt_q <= cur_cnt;
                    max_q <= cur_max;
                    min_q <= cur_min;
                    sum_q <= cur_sum;
                    no_q  <= cur_no;
                end
            end
        end
    end

endmodule

// File: rtl/ccd_line_classifier.sv
module ccd_line_classifier
    import ccd_pkg::*;
#(
    parameter int DW       = 12,
    parameter int LEAD     = 69,
    parameter int OB_FIRST = 18,
    parameter int OB_LAST  = 67,
    parameter int EFF      = 10680,
    parameter int TRAIL    = 6,
    parameter int BLK      = 100
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic                                 in_sol,
    input  logic [DW-1:0]                        in_sample,
    input  logic                                 meas_mode,
    output logic                                 out_valid,
    output logic [1:0]                           out_tag,
    output logic [DW-1:0]                        out_pix,
    output logic [$clog2(EFF+1)-1:0]             out_idx,
    output logic                                 line_err,
    output logic [DW-1:0]                        black_level,
    output logic                                 black_valid,
    output logic                                 blk_valid,
    output logic [$clog2((EFF+BLK-1)/BLK+1)-1:0] blk_idx,
    output logic [DW-1:0]                        blk_max,
    output logic [DW-1:0]                        blk_min,
    output logic [DW-1:0]                        blk_mean
);
    localparam int LINE = LEAD + EFF + TRAIL;
    localparam int PW   = $clog2(LINE + 1);
    localparam int IW   = $clog2(EFF + 1);
    localparam int OBN  = OB_LAST - OB_FIRST + 1;
    localparam int OSW  = DW + $clog2(OBN + 1);

    line_state_t      state_q, state_d;
    logic [PW-1:0]    pos_q, pos_d;
    logic             accept, abort;
    pix_tag_t         tag_d;
    logic [IW-1:0]    eidx_d;
    logic             meas_q;
    logic [OSW-1:0]   ob_sum_q, ob_next;
    logic [DW-1:0]    black_d;
    logic [DW:0]      diff;
    logic [DW-1:0]    corr;
    logic             blk_en;

    // position, class and next state
    always_comb begin
        accept = in_valid && (in_sol || state_q != S_IDLE);
        abort  = accept && in_sol && state_q != S_IDLE;
        pos_d  = in_sol ? PW'(1) : pos_q + 1'b1;

        tag_d  = TAG_DUMMY;
        eidx_d = '0;
        if (pos_d >= PW'(OB_FIRST) && pos_d <= PW'(OB_LAST)) begin
            tag_d = TAG_OB;
        end else if (pos_d > PW'(LEAD) && pos_d <= PW'(LEAD + EFF)) begin
            tag_d  = TAG_EFF;
            eidx_d = IW'(pos_d - PW'(LEAD));
        end

        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = S_LEAD;                       // START
            end
            S_LEAD: begin
                if (abort) state_d = S_LEAD;                        // ABORT
                else if (accept && pos_d > PW'(LEAD)) state_d = S_EFF; // TO_EFF
            end
            S_EFF: begin
                if (abort) state_d = S_LEAD;                        // ABORT
                else if (accept && pos_d == PW'(LINE)) state_d = S_IDLE; // DONE
                else if (accept && pos_d > PW'(LEAD + EFF)) state_d = S_TRAIL; // TO_TRAIL
            end
            S_TRAIL: begin
                if (abort) state_d = S_LEAD;                        // ABORT
                else if (accept && pos_d == PW'(LINE)) state_d = S_IDLE; // DONE
            end
            default: state_d = S_IDLE;
        endcase

        ob_next = (pos_d == PW'(OB_FIRST)) ? OSW'(in_sample)
                                            : ob_sum_q + OSW'(in_sample);
        diff    = {1'b0, in_sample} - {1'b0, black_level};
        corr    = diff[DW] ? '0 : diff[DW-1:0];
        blk_en  = accept && (tag_d == TAG_EFF) && meas_q;
    end

    recip_mean #(.NUMW(OSW), .DIV(OBN), .OUTW(DW)) u_black (
        .num  (ob_next),
        .mean (black_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) pos_q <= pos_d;
        end
    end

    // outputs and line accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_tag     <= TAG_DUMMY;
            out_pix     <= '0;
            out_idx     <= '0;
            line_err    <= 1'b0;
            black_level <= '0;
            black_valid <= 1'b0;
            meas_q      <= 1'b0;
            ob_sum_q    <= '0;
        end else begin
            out_valid <= accept;
            line_err  <= abort;
            if (accept) begin
                out_tag <= tag_d;
                out_idx <= eidx_d;
                out_pix <= (tag_d == TAG_EFF) ? corr : in_sample;
                if (in_sol) begin
                    meas_q      <= meas_mode;
                    black_valid <= 1'b0;
                end
                if (tag_d == TAG_OB) ob_sum_q <= ob_next;
                if (pos_d == PW'(OB_LAST)) begin
                    black_level <= black_d;
                    black_valid <= 1'b1;
                end
            end
        end
    end

    blk_stats #(.DW(DW), .BLK(BLK), .EFF(EFF)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (blk_en),
        .first     (eidx_d == IW'(1)),
        .last      (eidx_d == IW'(EFF)),
        .sample    (in_sample),
        .blk_valid (blk_valid),
        .blk_idx   (blk_idx),
        .blk_max   (blk_max),
        .blk_min   (blk_min),
        .blk_mean  (blk_mean)
    );

endmodule

// File: rtl/ccd_line_chk.sv
module ccd_line_chk #(
    parameter int DW  = 12,
    parameter int EFF = 10680,
    parameter int BLK = 100
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 in_valid,
    input logic                                 out_valid,
    input logic [1:0]                           out_tag,
    input logic [$clog2(EFF+1)-1:0]             out_idx,
    input logic                                 line_err,
    input logic                                 black_valid,
    input logic                                 blk_valid,
    input logic [DW-1:0]                        blk_max,
    input logic [DW-1:0]                        blk_min,
    input logic [DW-1:0]                        blk_mean
);
    localparam int IW = $clog2(EFF + 1);

    assert_eff_index_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd2) |-> (out_idx >= IW'(1) && out_idx <= IW'(EFF)));

    assert_tag_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag != 2'd3));

    assert_output_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_black_before_eff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd2) |-> black_valid);

    assert_mean_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (blk_min <= blk_mean && blk_mean <= blk_max));

    assert_block_on_eff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (out_valid && out_tag == 2'd2));

    assert_err_on_line_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> (out_valid && out_tag == 2'd0));

endmodule

bind ccd_line_classifier ccd_line_chk #(.DW(DW), .EFF(EFF), .BLK(BLK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_tag     (out_tag),
    .out_idx     (out_idx),
    .line_err    (line_err),
    .black_valid (black_valid),
    .blk_valid   (blk_valid),
    .blk_max     (blk_max),
    .blk_min     (blk_min),
    .blk_mean    (blk_mean)
);

// File: tb/ccd_line_classifier_tb_top.sv
module ccd_line_classifier_tb_top;
    localparam int DW       = 8;
    localparam int LEAD     = 10;
    localparam int OB_FIRST = 3;
    localparam int OB_LAST  = 7;
    localparam int EFF      = 23;
    localparam int TRAIL    = 2;
    localparam int BLK      = 5;
    localparam int LINE     = LEAD + EFF + TRAIL;
    localparam int OBN      = OB_LAST - OB_FIRST + 1;
    localparam int IW       = $clog2(EFF + 1);
    localparam int BW       = $clog2((EFF + BLK - 1) / BLK + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          meas_mode = 1'b0;
    logic          out_valid;
    logic [1:0]    out_tag;
    logic [DW-1:0] out_pix;
    logic [IW-1:0] out_idx;
    logic          line_err;
    logic [DW-1:0] black_level;
    logic          black_valid;
    logic          blk_valid;
    logic [BW-1:0] blk_idx;
    logic [DW-1:0] blk_max, blk_min, blk_mean;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    ccd_line_classifier #(
        .DW(DW), .LEAD(LEAD), .OB_FIRST(OB_FIRST), .OB_LAST(OB_LAST),
        .EFF(EFF), .TRAIL(TRAIL), .BLK(BLK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_sample(in_sample), .meas_mode(meas_mode), .out_valid(out_valid),
        .out_tag(out_tag), .out_pix(out_pix), .out_idx(out_idx),
        .line_err(line_err), .black_level(black_level), .black_valid(black_valid),
        .blk_valid(blk_valid), .blk_idx(blk_idx), .blk_max(blk_max),
        .blk_min(blk_min), .blk_mean(blk_mean)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(input int seed, input int p);
        return (p * p * 7 + seed * 31 + p * 11) % 256;
    endfunction

    // drive one sample at a falling edge; return at the next falling edge
    task automatic push(input int s, input bit sol, input bit mm);
        in_valid  = 1'b1;
        in_sample = DW'(s);
        in_sol    = sol;
        meas_mode = mm;
        @(negedge clk);
        in_sol = 1'b0;
    endtask

    task automatic t_idle_probe(input string tag);
        in_valid  = 1'b1;
        in_sol    = 1'b0;
        in_sample = 8'd55;
        @(negedge clk);
        chk(out_valid == 1'b0, {"R2 ", tag}, int'(out_valid), 0);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0,   "R10 out_valid",   int'(out_valid), 0);
        chk(line_err == 1'b0,    "R10 line_err",    int'(line_err), 0);
        chk(black_valid == 1'b0, "R10 black_valid", int'(black_valid), 0);
        chk(blk_valid == 1'b0,   "R10 blk_valid",   int'(blk_valid), 0);
        chk(black_level == '0,   "R10 black_level", int'(black_level), 0);
    endtask

    // run n samples of a line, checking every output against the requirements
    task automatic run_line(input int n, input int seed, input bit meas, input bit exp_err);
        int obsum = 0;
        int black = 0;
        int bmax = 0, bmin = 0, bsum = 0, bcnt = 0, bno = 0;
        for (int p = 1; p <= n; p++) begin
            int s = gen(seed, p);
            int etag;
            push(s, p == 1, (p == 1) ? meas : !meas);   // R8: later changes ignored
            if (p >= OB_FIRST && p <= OB_LAST) etag = 1;
            else if (p > LEAD && p <= LEAD + EFF) etag = 2;
            else etag = 0;
            chk(out_valid == 1'b1, "R1 out_valid", int'(out_valid), 1);
            chk(int'(out_tag) == etag, "R1 out_tag", int'(out_tag), etag);
            chk(line_err == (p == 1 && exp_err), "R9 line_err",
                int'(line_err), int'(p == 1 && exp_err));
            if (p == 1)
                chk(black_valid == 1'b0, "R3 black_valid cleared", int'(black_valid), 0);
            if (etag == 1) begin
                obsum += s;
                if (p == OB_LAST) begin
                    black = (obsum + OBN / 2) / OBN;
                    chk(int'(black_level) == black, "R3 black_level", int'(black_level), black);
                    chk(black_valid == 1'b1, "R3 black_valid", int'(black_valid), 1);
                end
            end
            if (etag == 2) begin
                int i = p - LEAD;
                int e = (s > black) ? s - black : 0;
                chk(int'(out_idx) == i, "R1 out_idx", int'(out_idx), i);
                chk(int'(out_pix) == e, "R4 corrected pixel", int'(out_pix), e);
                if (bcnt == 0) begin bmax = s; bmin = s; bsum = 0; end
                if (s > bmax) bmax = s;
                if (s < bmin) bmin = s;
                bsum += s;
                bcnt++;
                if (meas && (bcnt == BLK || i == EFF)) begin
                    int m = (bsum + bcnt / 2) / bcnt;
                    string rq = (bcnt == BLK) ? "R6" : "R7";
                    chk(blk_valid == 1'b1, {rq, " blk_valid"}, int'(blk_valid), 1);
                    chk(int'(blk_idx) == bno, {rq, " blk_idx"}, int'(blk_idx), bno);
                    chk(int'(blk_max) == bmax, {rq, " blk_max"}, int'(blk_max), bmax);
                    chk(int'(blk_min) == bmin, {rq, " blk_min"}, int'(blk_min), bmin);
                    chk(int'(blk_mean) == m, {rq, " blk_mean"}, int'(blk_mean), m);
                    bno++;
                    bcnt = 0;
                end else begin
                    if (bcnt == BLK) bcnt = 0;
                    chk(blk_valid == 1'b0, "R8 no block report", int'(blk_valid), 0);
                end
            end else begin
                chk(int'(out_pix) == s, "R5 raw pixel", int'(out_pix), s);
                chk(blk_valid == 1'b0, "R6 no block on non-effective", int'(blk_valid), 0);
            end
        end
        in_valid = 1'b0;
        meas_mode = 1'b0;
    endtask

    task automatic t_normal_line;
        run_line(LINE, 3, 1'b0, 1'b0);
        t_idle_probe("after complete line");
    endtask

    task automatic t_meas_line;
        run_line(LINE, 5, 1'b1, 1'b0);
        t_idle_probe("after measured line");
    endtask

    task automatic t_abort_line;
        run_line(18, 7, 1'b1, 1'b0);     // stops inside block 1
        run_line(LINE, 11, 1'b1, 1'b1);  // R9: early start, then clean line
        @(negedge clk);
        chk(line_err == 1'b0, "R9 no stray error", int'(line_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle_probe("before first line");
        t_normal_line();
        t_meas_line();
        t_abort_line();
        run_line(LINE, 19, 1'b1, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule